// File: doc/BRIEF.md
# Countdown Timer Channel Bank

This block holds five countdown channels that software controls through one shared control word and a set of per-channel buffer registers. Software writes a count value into a channel's buffer, copies it into the live counter with a manual-load bit, and runs or halts the channel with a start bit. Channels 0 to 3 also hold a compare value for a waveform stage that lives outside this block. Channel 4 has no compare buffer and no invert bit.

Each running channel counts down by one on every pulse of its count-enable strobe. When a strobe arrives while the count is already zero, the channel pulses its expiry output. It then either reloads from its buffer and keeps running, or stops and clears its own start bit in the control word. Control actions fire only on 0-to-1 or 1-to-0 changes of the written bits, compared with the stored word. Read data is combinational from the address.

Top module: `cdown_timer_bank`

## Requirements
- R1: After reset the control word, every count buffer, every compare buffer and every live counter read zero, all channels are stopped, and no expiry pulse is driven.
- R2: The control word is at offset 0x08 and reads back as written. Channel 0 uses bit 0 for start, bit 1 for manual load, bit 2 for invert and bit 3 for auto-reload. Channel n (1..3) uses the same order starting at bit 4n+4. Channel 4 uses bit 20 for start, bit 21 for manual load and bit 22 for auto-reload.
- R3: A control write that takes a channel's manual-load bit from 0 to 1 copies its count buffer into its live counter. Writing the bit as 1 when it is already 1 leaves the counter unchanged.
- R4: A control write that takes a start bit from 0 to 1 runs that channel. One that takes it from 1 to 0 halts the channel, and the count is held.
- R5: A running channel's counter drops by one on each cycle its strobe tick_i[n] is high. Strobes to a stopped channel change nothing.
- R6: A strobe to a running channel whose count is zero drives expire_o[n] high in that cycle. With auto-reload set, the counter takes the count buffer and the start bit stays set.
- R7: On expiry without auto-reload, the channel stops, its start bit reads back as 0, and the counter stays at zero.
- R8: For channel n (0..3), the count buffer is at 0x0C+0xC·n, the compare buffer at 0x10+0xC·n and the live-count view at 0x14+0xC·n. Channel 4's count buffer is at 0x3C and its live-count view at 0x40. Buffers read back as written.
- R9: Writes to undefined offsets (such as 0x00, 0x04, 0x44) and to live-count views are ignored, and reads of undefined offsets return zero.
- R10: Strobes that arrive in the same cycle as a control write are ignored by every channel.
- R11: Writing a count buffer does not change the live counter until a manual load or an auto-reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte offset |
| we_i | input | 1 | Write strobe for addr_i |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| tick_i | input | 5 | Per-channel count-enable strobes |
| expire_o | output | 5 | Per-channel expiry pulses |

## Verification
The bench writes manual-load bits as fresh edges and as repeats of 1. This separates edge detection from level sensing. It starts, halts and restarts a channel partway through a countdown to show the count is held and resumed rather than reloaded. Expiry is driven both with and without auto-reload, on channel 0 and on channel 4, so that a wrong irregular bit position shows up as a missing reload or a start bit that is not cleared. All five strobes are pulsed together while a single middle channel runs, which exposes any channel that counts under another channel's start bit. A strobe that lands on a control write shows whether that write holds the counters.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH = 5;
  localparam int DATA_W = 32;
  localparam int CTRL_OFF = 'h08;

  function automatic int start_bit(int ch);
    return (ch == 0) ? 0 : 4 * ch + 4;
  endfunction

  function automatic int load_bit(int ch);
    return start_bit(ch) + 1;
  endfunction

  function automatic int arl_bit(int ch);
    return (ch == NUM_CH - 1) ? 22 : start_bit(ch) + 3;
  endfunction

  function automatic int cnt_off(int ch);
    return 'h0C + 12 * ch;
  endfunction

  function automatic int cmp_off(int ch);
    return 'h10 + 12 * ch;
  endfunction

  function automatic int obs_off(int ch);
    return (ch == NUM_CH - 1) ? 'h40 : 'h14 + 12 * ch;
  endfunction
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] clr_start_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [NUM_CH-1:0] load_o,
  output logic [NUM_CH-1:0] run_o,
  output logic [NUM_CH-1:0] arl_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    for (int c = 0; c < NUM_CH; c++) clr_mask[start_bit(c)] = clr_start_i[c];
  end

  // write stores whole word after edges are taken against the old value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i;
    else           ctrl_q <= ctrl_q & ~clr_mask;
  end

  assign ctrl_o = ctrl_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int SB = start_bit(c);
    localparam int MB = load_bit(c);
    localparam int AB = arl_bit(c);

    assign load_o[c] = we_i & wdata_i[MB] & ~ctrl_q[MB];
    assign run_o[c]  = ctrl_q[SB];
    assign arl_o[c]  = ctrl_q[AB];

    p_self_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_start_i[c] && !we_i |=> !ctrl_q[SB]);
  end

  p_ctrl_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i && clr_start_i == '0 |=> $stable(ctrl_q));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic             arl_i,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             stop_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;
  logic             zero;

  assign step     = run_i & tick_i & ~hold_i;
  assign zero     = (cnt_q == '0);
  assign expire_o = step & zero;
  assign stop_o   = expire_o & ~arl_i;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= buf_i;
    else if (step && !zero)     cnt_q <= cnt_q - 1'b1;
    else if (step && arl_i)     cnt_q <= buf_i;
  end

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(buf_i));
  p_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && !zero |=> cnt_q == $past(cnt_q) - 1'b1);
  p_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && arl_i |=> cnt_q == $past(buf_i));
  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !run_i |=> $stable(cnt_q));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && !load_i |=> $stable(cnt_q));
endmodule

// File: rtl/cdown_timer_bank.sv
module cdown_timer_bank
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] tick_i,
  output logic [NUM_CH-1:0] expire_o
);
  localparam int NUM_CMP = NUM_CH - 1;

  logic              ctrl_we;
  logic [DATA_W-1:0] ctrl;
  logic [NUM_CH-1:0] load, run, arl, stop;
  logic [CNT_W-1:0]  cnt_buf [NUM_CH];
  logic [CNT_W-1:0]  cmp_buf [NUM_CMP];
  logic [CNT_W-1:0]  cnt     [NUM_CH];

  assign ctrl_we = we_i && (addr_i == ADDR_W'(CTRL_OFF));

  tmr_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ctrl_we),
    .wdata_i     (wdata_i),
    .clr_start_i (stop),
    .ctrl_o      (ctrl),
    .load_o      (load),
    .run_o       (run),
    .arl_o       (arl)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_buf[c] <= '0;
      else if (we_i && addr_i == ADDR_W'(cnt_off(c))) cnt_buf[c] <= CNT_W'(wdata_i);
    end

    if (c < NUM_CMP) begin : g_cmp
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cmp_buf[c] <= '0;
        else if (we_i && addr_i == ADDR_W'(cmp_off(c))) cmp_buf[c] <= CNT_W'(wdata_i);
      end
    end

    tmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load[c]),
      .run_i    (run[c]),
      .arl_i    (arl[c]),
      .tick_i   (tick_i[c]),
      .hold_i   (ctrl_we),
      .buf_i    (cnt_buf[c]),
      .cnt_o    (cnt[c]),
      .expire_o (expire_o[c]),
      .stop_o   (stop[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CTRL_OFF)) rdata_o = ctrl;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(cnt_off(c))) rdata_o = DATA_W'(cnt_buf[c]);
      if (addr_i == ADDR_W'(obs_off(c))) rdata_o = DATA_W'(cnt[c]);
    end
    for (int c = 0; c < NUM_CMP; c++)
      if (addr_i == ADDR_W'(cmp_off(c))) rdata_o = DATA_W'(cmp_buf[c]);
  end

  p_expire_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o != '0 |-> !ctrl_we);
endmodule

// File: tb/sim_cdown_timer_bank.sv
module sim_cdown_timer_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [4:0]  tick_i = '0;
  logic [4:0]  expire_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  cdown_timer_bank u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #1 check(req, rdata_o, exp);
  endtask

  task automatic strobe(logic [4:0] m, logic [4:0] exp_exp, string req);
    @(negedge clk_i);
    tick_i = m;
    #1 check(req, {27'd0, expire_o}, {27'd0, exp_exp});
    @(posedge clk_i);
    #1 tick_i = '0;
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 8'h08, 0);
    for (int c = 0; c < 4; c++) rd_chk("R1 obs", 8'(8'h14 + 12 * c), 0);
    rd_chk("R1 obs4", 8'h40, 0);
    check("R1 expire", {27'd0, expire_o}, 0);
  endtask

  task automatic t_offsets;
    for (int c = 0; c < 5; c++) wr(8'(8'h0C + 12 * c), 32'h100 + c);
    for (int c = 0; c < 4; c++) wr(8'(8'h10 + 12 * c), 32'h200 + c);
    for (int c = 0; c < 5; c++) rd_chk("R8 cntbuf", 8'(8'h0C + 12 * c), 32'h100 + c);
    for (int c = 0; c < 4; c++) rd_chk("R8 cmpbuf", 8'(8'h10 + 12 * c), 32'h200 + c);
    rd_chk("R11 obs0 untouched", 8'h14, 0);
    wr(8'h14, 32'h55);
    rd_chk("R9 obs write ignored", 8'h14, 0);
    wr(8'h00, 32'hFFFF); wr(8'h04, 32'hFFFF); wr(8'h44, 32'hFFFF);
    rd_chk("R9 undef 00", 8'h00, 0);
    rd_chk("R9 undef 04", 8'h04, 0);
    rd_chk("R9 undef 44", 8'h44, 0);
    rd_chk("R9 ctrl untouched", 8'h08, 0);
  endtask

  task automatic t_layout;
    wr(8'h08, 32'h0002_2200);
    rd_chk("R2 ctrl readback", 8'h08, 32'h0002_2200);
    for (int c = 1; c < 4; c++) rd_chk("R2 load ch", 8'(8'h14 + 12 * c), 32'h100 + c);
    rd_chk("R2 ch0 not loaded", 8'h14, 0);
    wr(8'h08, 32'h0000_1000);
    strobe(5'h1F, 5'h00, "R5 strobe all");
    rd_chk("R2 ch1 stopped", 8'h20, 32'h101);
    rd_chk("R2 ch2 counted", 8'h2C, 32'h101);
    rd_chk("R2 ch3 stopped", 8'h38, 32'h103);
  endtask

  task automatic t_manual;
    wr(8'h08, 32'h2);
    rd_chk("R3 load ch0", 8'h14, 32'h100);
    wr(8'h0C, 32'd5);
    rd_chk("R11 buf no effect", 8'h14, 32'h100);
    wr(8'h08, 32'h2);
    rd_chk("R3 repeat 1 no load", 8'h14, 32'h100);
    wr(8'h08, 32'h0);
    wr(8'h08, 32'h2);
    rd_chk("R3 fresh edge loads", 8'h14, 32'd5);
  endtask

  task automatic t_count_stop;
    wr(8'h08, 32'h1);
    rd_chk("R3 no reload on start", 8'h14, 32'd5);
    for (int i = 0; i < 3; i++) strobe(5'h01, 5'h00, "R5 no expire");
    rd_chk("R5 dec by 3", 8'h14, 32'd2);
    wr(8'h08, 32'h0);
    strobe(5'h01, 5'h00, "R4 stopped no expire");
    rd_chk("R4 halted hold", 8'h14, 32'd2);
    wr(8'h08, 32'h1);
    strobe(5'h01, 5'h00, "R5 resume");
    strobe(5'h01, 5'h00, "R5 reach zero");
    rd_chk("R5 at zero", 8'h14, 32'd0);
    strobe(5'h01, 5'h01, "R6 expire pulse");
    rd_chk("R7 start cleared", 8'h08, 32'h0);
    rd_chk("R7 count zero", 8'h14, 32'd0);
    strobe(5'h01, 5'h00, "R7 no further expire");
  endtask

  task automatic t_reload4;
    wr(8'h3C, 32'd2);
    wr(8'h08, 32'h0020_0000);
    rd_chk("R3 ch4 load", 8'h40, 32'd2);
    wr(8'h08, 32'h0050_0000);
    strobe(5'h10, 5'h00, "R5 ch4 dec");
    strobe(5'h10, 5'h00, "R5 ch4 dec");
    strobe(5'h10, 5'h10, "R6 ch4 expire");
    rd_chk("R6 ch4 reloaded", 8'h40, 32'd2);
    rd_chk("R6 start kept", 8'h08, 32'h0050_0000);
    strobe(5'h10, 5'h00, "R6 runs on");
    rd_chk("R6 ch4 after reload", 8'h40, 32'd1);
  endtask

  task automatic t_collide;
    wr(8'h0C, 32'd7);
    wr(8'h08, 32'h2);
    wr(8'h08, 32'h3);
    rd_chk("R3 load before run", 8'h14, 32'd7);
    @(negedge clk_i);
    addr_i = 8'h08; wdata_i = 32'h3; we_i = 1'b1; tick_i = 5'h01;
    @(posedge clk_i);
    #1 we_i = 1'b0; tick_i = '0;
    rd_chk("R10 strobe ignored", 8'h14, 32'd7);
    strobe(5'h01, 5'h00, "R5 after collide");
    rd_chk("R10 counts after", 8'h14, 32'd6);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_offsets();
    t_layout();
    t_manual();
    t_count_stop();
    t_reload4();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule